// File: doc/BRIEF.md
# Processor Sleep-State Controller

This block sits beside a small processor core and decides when the core's clock and the clocks of everything else may run. Software writes a three-bit control word that asks for a light sleep, a deep sleep, or arms a watchdog for a missing clock. A sleep request takes effect only once the core reports that the instruction which wrote the word has completed.

In light sleep only the core and its program memory lose their clock. Peripherals and oscillators keep running, and any pending interrupt that is also enabled brings the core back. In deep sleep every clock is halted and interrupts are ignored. Only a reset ends it. A reset can come from an external request, a comparator, an external convert-start strobe, or the built-in missing-clock detector. The detector counts ticks of a free-running low-rate reference while the system clocks are halted, and fires a reset when the count reaches a programmed limit (100 ticks of a 1 MHz reference by default, 100 us).

A reset clears the control word, returns all clock enables to active, and holds the core in reset for a fixed number of cycles. The core then restarts from its reset address.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low and for exactly RST_HOLD clock cycles after it rises, `cpu_rst` is high. Both clock enables are high, and `ctl_rdata` reads 0.
- R2: The control word reads back on `ctl_rdata` as written: bit 0 requests light sleep, bit 1 requests deep sleep, bit 2 enables the missing-clock detector. A light-sleep request leaves `cpu_clk_en` high until `insn_done` is seen. From the cycle after that, `cpu_clk_en` is low and `per_clk_en` stays high.
- R3: In light sleep, an interrupt whose request and enable bits are both set raises `cpu_clk_en` on the next cycle and clears bit 0. A request whose enable bit is low has no effect.
- R4: Any reset source asserted during light sleep raises `cpu_rst` and clears bits 0 and 1.
- R5: A deep-sleep request followed by `insn_done` drives both `cpu_clk_en` and `per_clk_en` low.
- R6: Deep sleep ignores enabled interrupts. Each of `ext_rst_req`, `cmp_rst_req` and `cnv_rst_req` ends it through `cpu_rst`.
- R7: With bit 2 set in deep sleep, `cpu_rst` stays low after MCD_LIMIT-1 reference ticks and rises within two cycles after tick number MCD_LIMIT.
- R8: With bit 2 clear, deep sleep persists through any number of reference ticks.
- R9: When bits 0 and 1 are both set, deep sleep is entered.
- R10: A reset clears all three control bits and has both clock enables high before `cpu_rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word write data |
| ctl_rdata | output | 3 | Control word read-back |
| insn_done | input | 1 | Core reports the current instruction completed |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| ext_rst_req | input | 1 | External reset request |
| cmp_rst_req | input | 1 | Comparator reset request |
| cnv_rst_req | input | 1 | External convert-start reset request |
| ref_tick | input | 1 | One-cycle tick from the low-rate reference |
| cpu_clk_en | output | 1 | Clock enable for core and program memory |
| per_clk_en | output | 1 | Clock enable for peripherals and oscillators |
| cpu_rst | output | 1 | Core reset, restarts at address zero |

## Verification
The bench sweeps all eight control words and computes the sleep depth each one should give. A controller that resolved the double request toward light sleep would keep `per_clk_en` high. It then leaves each state by every legal path. An interrupt in deep sleep or a masked interrupt in light sleep must change nothing; a design that ORed requests without enables would wake early. The detector is driven to one tick short of its limit and then to the limit. An off-by-one comparator would reset too early or one tick late, and a detector that ignored its enable would break a deep sleep that should last.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STOP = 2'd2
  } lpm_mode_e;

  localparam int CTL_W    = 3;
  localparam int BIT_IDLE = 0;
  localparam int BIT_STOP = 1;
  localparam int BIT_MCD  = 2;
endpackage

// File: rtl/lpm_modereg.sv
module lpm_modereg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             insn_done,
  input  logic             wake,
  output lpm_mode_e        mode_o,
  output logic [CTL_W-1:0] ctl_o
);
  lpm_mode_e        mode_q, mode_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    mode_d = mode_q;
    ctl_d  = ctl_q;
    if (sync_clr) begin
      mode_d = MODE_RUN;
      ctl_d  = '0;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (insn_done && ctl_q[BIT_STOP])      mode_d = MODE_STOP;
          else if (insn_done && ctl_q[BIT_IDLE]) mode_d = MODE_IDLE;
          if (ctl_we) ctl_d = ctl_wdata;
        end
        MODE_IDLE: begin
          if (wake) begin
            mode_d          = MODE_RUN;
            ctl_d[BIT_IDLE] = 1'b0;
          end
        end
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      ctl_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ctl_q  <= ctl_d;
    end
  end

  assign mode_o = mode_q;
  assign ctl_o  = ctl_q;

  // R3: an enabled interrupt ends light sleep on the next edge
  a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && wake && !sync_clr) |=> (mode_q == MODE_RUN && !ctl_q[BIT_IDLE]));

  // R9: a deep request outranks a light one
  a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && insn_done && ctl_q[BIT_STOP] && !sync_clr) |=> (mode_q == MODE_STOP));
endmodule

// File: rtl/lpm_mcd.sv
module lpm_mcd #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic clk_run,
  input  logic ref_tick,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !en || clk_run)                     cnt_d = '0;
    else if (ref_tick && cnt_q != CW'(LIMIT))      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == CW'(LIMIT));

  // R7: the detector can only trip on a reference tick
  a_r7_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire) |-> $past(ref_tick));

  // R8: a disabled detector stays quiet
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fire);
endmodule

// File: rtl/lpm_rstseq.sv
module lpm_rstseq #(
  parameter int HOLD  = 4,
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  output logic             core_rst
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (|src)            cnt_d = HW'(HOLD);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= HW'(HOLD);
    else        cnt_q <= cnt_d;
  end

  assign core_rst = (cnt_q != 0);

  // R1: a source always produces reset on the next cycle
  a_r1_src_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> core_rst);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int MCD_LIMIT = 100,
  parameter int RST_HOLD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             insn_done,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             ext_rst_req,
  input  logic             cmp_rst_req,
  input  logic             cnv_rst_req,
  input  logic             ref_tick,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             cpu_rst
);
  localparam int N_SRC = 4;

  lpm_mode_e        mode;
  logic [CTL_W-1:0] ctl;
  logic             wake, mcd_fire;
  logic [N_SRC-1:0] rst_src;

  assign wake    = |(irq_req & irq_en);
  assign rst_src = {mcd_fire, cnv_rst_req, cmp_rst_req, ext_rst_req};

  lpm_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .sync_clr(cpu_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .insn_done(insn_done),
    .wake(wake), .mode_o(mode), .ctl_o(ctl)
  );

  lpm_mcd #(.LIMIT(MCD_LIMIT)) u_mcd (
    .clk(clk), .rst_n(rst_n), .clr(cpu_rst), .en(ctl[BIT_MCD]),
    .clk_run(per_clk_en), .ref_tick(ref_tick), .fire(mcd_fire)
  );

  lpm_rstseq #(.HOLD(RST_HOLD), .N_SRC(N_SRC)) u_rst (
    .clk(clk), .rst_n(rst_n), .src(rst_src), .core_rst(cpu_rst)
  );

  assign cpu_clk_en = (mode == MODE_RUN);
  assign per_clk_en = (mode != MODE_STOP);
  assign ctl_rdata  = ctl;

  // R6: peripheral clocks only return from deep sleep through reset
  a_r6_stop_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_clk_en) |-> cpu_rst);

  // R10: clocks are running before the core leaves reset
  a_r10_clocks_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> (cpu_clk_en && per_clk_en && ctl_rdata == '0));
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NI = 4, LIM = 20, HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, insn_done = 1'b0, ref_tick = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic [2:0] ctl_rdata;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic ext_rst_req = 1'b0, cmp_rst_req = 1'b0, cnv_rst_req = 1'b0;
  logic cpu_clk_en, per_clk_en, cpu_rst;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_ctrl #(.N_IRQ(NI), .MCD_LIMIT(LIM), .RST_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .insn_done(insn_done), .irq_req(irq_req),
    .irq_en(irq_en), .ext_rst_req(ext_rst_req), .cmp_rst_req(cmp_rst_req),
    .cnv_rst_req(cnv_rst_req), .ref_tick(ref_tick), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .cpu_rst(cpu_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(1); ctl_we = 1'b0;
  endtask

  task automatic retire();
    insn_done = 1'b1; step(1); insn_done = 1'b0;
  endtask

  task automatic wait_rel(output int cyc);
    cyc = 0;
    while (cpu_rst && cyc < 1000) begin step(1); cyc++; end
  endtask

  task automatic pulse_src(input int which);
    case (which)
      0: ext_rst_req = 1'b1;
      1: cmp_rst_req = 1'b1;
      default: cnv_rst_req = 1'b1;
    endcase
    step(1);
    ext_rst_req = 1'b0; cmp_rst_req = 1'b0; cnv_rst_req = 1'b0;
  endtask

  task automatic tick();
    ref_tick = 1'b1; step(1); ref_tick = 1'b0; step(1);
  endtask

  initial begin
    int cyc;
    step(3);
    chk("R1 reset held", cpu_rst, 1);
    chk("R1 cpu en in reset", cpu_clk_en, 1);
    rst_n = 1'b1;
    wait_rel(cyc);
    chk("R1 hold length", cyc, HOLD);
    chk("R1 readback", ctl_rdata, 0);
    chk("R1 per en", per_clk_en, 1);

    // sweep of all control words (R2, R5, R9)
    for (int v = 0; v < 8; v++) begin
      wr(3'(v));
      chk("R2 readback", ctl_rdata, v);
      chk("R2 cpu en before retire", cpu_clk_en, 1);
      retire();
      chk("R2/R5/R9 cpu en", cpu_clk_en, (v & 3) == 0 ? 1 : 0);
      chk("R2/R5/R9 per en", per_clk_en, (v & 2) != 0 ? 0 : 1);
      if ((v & 2) != 0) begin
        pulse_src(0);
        wait_rel(cyc);
        chk("R10 readback after reset", ctl_rdata, 0);
      end else if ((v & 1) != 0) begin
        irq_req = 4'b0100; irq_en = 4'b0100; step(1);
        irq_req = '0; irq_en = '0;
        chk("R3 wake", cpu_clk_en, 1);
        chk("R3 bit0 cleared", ctl_rdata, v & 6);
      end
    end
    wr(3'b000);

    // R3 masked interrupt in light sleep
    wr(3'b001); retire();
    irq_req = 4'b1011; irq_en = 4'b0100; step(3);
    chk("R3 masked irq ignored", cpu_clk_en, 0);
    chk("R3 masked bit0 kept", ctl_rdata, 1);
    irq_en = 4'b0001; step(1);
    irq_req = '0; irq_en = '0;
    chk("R3 enabled irq wakes", cpu_clk_en, 1);

    // R4 reset sources during light sleep
    for (int s = 0; s < 3; s++) begin
      wr(3'b001); retire();
      pulse_src(s);
      chk("R4 reset in idle", cpu_rst, 1);
      step(1);
      chk("R4 bits cleared", ctl_rdata, 0);
      wait_rel(cyc);
      chk("R10 enables after release", {cpu_clk_en, per_clk_en}, 3);
    end

    // R6 deep sleep ignores interrupts, exits by each source
    for (int s = 0; s < 3; s++) begin
      wr(3'b010); retire();
      irq_req = '1; irq_en = '1; step(5);
      irq_req = '0; irq_en = '0;
      chk("R6 irq ignored in stop", {cpu_clk_en, per_clk_en, cpu_rst}, 0);
      pulse_src(s);
      chk("R6 source resets", cpu_rst, 1);
      wait_rel(cyc);
      chk("R6 cycles to release", cyc, HOLD);
      chk("R10 enables up", {cpu_clk_en, per_clk_en}, 3);
    end

    // R7 missing-clock detector at its limit
    wr(3'b110); retire();
    for (int i = 0; i < LIM - 1; i++) tick();
    chk("R7 no reset one tick short", cpu_rst, 0);
    chk("R7 still stopped", per_clk_en, 0);
    tick();
    chk("R7 reset at limit", cpu_rst, 1);
    wait_rel(cyc);
    chk("R10 mcd bit cleared", ctl_rdata, 0);
    chk("R10 enables after mcd", {cpu_clk_en, per_clk_en}, 3);

    // R8 detector disabled
    wr(3'b010); retire();
    for (int i = 0; i < 3 * LIM; i++) tick();
    chk("R8 no reset when disabled", cpu_rst, 0);
    chk("R8 stop persists", per_clk_en, 0);
    pulse_src(2);
    wait_rel(cyc);
    chk("R8 exit by source", per_clk_en, 1);

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule